// File: doc/BRIEF.md
# Real-Time Counter Event Channels

This block watches a free-running real-time counter and raises events at programmed times. It sees the counter as a 32-bit time view: the low 16 bits of the whole-second count joined to the upper 16 bits of the fractional second. In that format one second is 0x0001_0000. Three channels compare the view against their own compare registers:

- Channel 0 only compares.
- Channel 1 either compares or captures the time view on a rising edge of an external event.
- Channel 2 compares and can reload itself, adding a programmed increment to its compare value on every hit, to give a periodic event.

Each channel drives a one-cycle event pulse and a sticky flag that software clears by writing 1. A channel fires when the time view has reached its compare value or passed it by less than one second. A compare value written slightly in the past therefore fires at once. A channel is armed by a write to its compare register and fires once per arming. Channel 2 in continuous mode re-arms itself after each reload.

Software reaches the block through a single-cycle write port and a combinational read port, both addressed by a 3-bit word index.

Top module: `rtc_event_channels`

## Requirements
- R1: After reset, all flags and event pulses are 0 and every readable register reads 0. Channels are disarmed.
- R2: An enabled, armed compare channel fires when (time − compare) mod 2^32 < 0x0001_0000.
  - The condition is evaluated at a clock edge.
  - The event pulse goes high for one cycle after that edge.
  - The flag sets at that same edge.
- R3: A compare channel that is not in continuous mode fires only once after each write to its compare register.
- R4: A compare value written up to 0xFFFF below the current time view fires on the first edge after the write. A value 0x0001_0000 or more below the view, or above it, does not fire.
- R5: The flags for channels 0, 1 and 2 read at status bits 0, 8 and 16 (address 1).
  - A flag stays set until a write of 1 to its bit clears it.
  - Writing 0 has no effect.
  - A set in the same cycle as a clear wins.
- R6: A disabled channel neither sets its flag nor captures. It stays armed, and fires once it is enabled.
- R7: With channel 1 enabled and in capture mode, each rising edge of `capt_in` does three things:
  - It latches the time view sampled at that edge into the capture register (address 6).
  - It sets flag 1.
  - It pulses event 1.
  In capture mode, channel 1 compare matches are ignored.
- R8: With channel 2 in continuous mode, each channel 2 hit adds the increment (address 5) to the channel 2 compare value and leaves the channel armed.
- R9: Register map by word address, with all unlisted bits reading 0:
  - 0: control. Enables for channels 0, 1 and 2 at bits 0, 8 and 16; capture mode at bit 9; continuous mode at bit 18.
  - 1: flags.
  - 2, 3 and 4: compare 0, 1 and 2.
  - 5: increment.
  - 6: capture, read-only.
  - 7: reads 0.
- R10: A compare-register write in the same cycle as that channel's match wins. It loads the new value, re-arms the channel, and suppresses that cycle's hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Combinational read data |
| time_view | input | 32 | {seconds[15:0], fraction[31:16]} of the counter |
| capt_in | input | 1 | Capture event for channel 1, synchronous to clk |
| chan_flag | output | 3 | Sticky event flags, one per channel |
| chan_evt | output | 3 | One-cycle event pulses, one per channel |

## Verification
The assertions assume that `time_view` and `capt_in` are already synchronous to `clk` and hold stable between edges. They also assume that at most one register is written per cycle. The window check relies on the view moving forward by much less than one second per cycle, so that a match cannot be skipped over. The bench drives every input at the falling edge. It advances the view either by a fixed 0x100 per cycle or not at all, which keeps the stimulus inside these assumptions while still covering both window boundaries exactly.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
  localparam int NUM_CH = 3;
  localparam int CH_STRIDE = 8;
  localparam int CAPT_MODE_BIT = 9;
  localparam int CONT_MODE_BIT = 18;

  typedef enum logic [2:0] {
    ADR_CTRL  = 3'd0,
    ADR_FLAGS = 3'd1,
    ADR_CMP0  = 3'd2,
    ADR_CMP1  = 3'd3,
    ADR_CMP2  = 3'd4,
    ADR_INC   = 3'd5,
    ADR_CAPT  = 3'd6,
    ADR_NONE  = 3'd7
  } reg_adr_e;
endpackage

// File: rtl/rtc_evt_cfg.sv
module rtc_evt_cfg
  import rtc_evt_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [TW-1:0]     wr_data,
  input  logic [2:0]        rd_addr,
  input  logic [TW-1:0]     cmp0_i,
  input  logic [TW-1:0]     cmp1_i,
  input  logic [TW-1:0]     cmp2_i,
  input  logic [TW-1:0]     capt_i,
  input  logic [NUM_CH-1:0] flag_i,
  output logic [TW-1:0]     rd_data,
  output logic [NUM_CH-1:0] ch_en_o,
  output logic              capt_mode_o,
  output logic              cont_mode_o,
  output logic [TW-1:0]     inc_o,
  output logic [NUM_CH-1:0] load_o,
  output logic [NUM_CH-1:0] clr_o
);
  logic [NUM_CH-1:0] en_q, en_d;
  logic              capm_q, capm_d, cont_q, cont_d;
  logic [TW-1:0]     inc_q, inc_d;
  logic              ctrl_we, inc_we, flags_we;

  assign ctrl_we  = wr_en && (wr_addr == ADR_CTRL);
  assign inc_we   = wr_en && (wr_addr == ADR_INC);
  assign flags_we = wr_en && (wr_addr == ADR_FLAGS);

  assign load_o[0] = wr_en && (wr_addr == ADR_CMP0);
  assign load_o[1] = wr_en && (wr_addr == ADR_CMP1);
  assign load_o[2] = wr_en && (wr_addr == ADR_CMP2);

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_fld
      assign clr_o[g] = flags_we && wr_data[g*CH_STRIDE];
      assign en_d[g]  = wr_data[g*CH_STRIDE];
    end
  endgenerate

  assign capm_d = wr_data[CAPT_MODE_BIT];
  assign cont_d = wr_data[CONT_MODE_BIT];
  assign inc_d  = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      capm_q <= 1'b0;
      cont_q <= 1'b0;
    end else if (ctrl_we) begin
      en_q   <= en_d;
      capm_q <= capm_d;
      cont_q <= cont_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      inc_q <= '0;
    else if (inc_we) inc_q <= inc_d;
  end

  assign ch_en_o     = en_q;
  assign capt_mode_o = capm_q;
  assign cont_mode_o = cont_q;
  assign inc_o       = inc_q;

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADR_CTRL: begin
        for (int i = 0; i < NUM_CH; i++) rd_data[i*CH_STRIDE] = en_q[i];
        rd_data[CAPT_MODE_BIT] = capm_q;
        rd_data[CONT_MODE_BIT] = cont_q;
      end
      ADR_FLAGS: begin
        for (int i = 0; i < NUM_CH; i++) rd_data[i*CH_STRIDE] = flag_i[i];
      end
      ADR_CMP0: rd_data = cmp0_i;
      ADR_CMP1: rd_data = cmp1_i;
      ADR_CMP2: rd_data = cmp2_i;
      ADR_INC:  rd_data = inc_q;
      ADR_CAPT: rd_data = capt_i;
      default:  rd_data = '0;
    endcase
  end

  // R9
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(en_q) && $stable(capm_q) && $stable(cont_q));
endmodule

// File: rtl/rtc_cmp_unit.sv
module rtc_cmp_unit #(
  parameter int TW          = 32,
  parameter int WIN_BITS    = 16,
  parameter bit AUTO_RELOAD = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en_i,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          cont_i,
  input  logic [TW-1:0] inc_i,
  input  logic [TW-1:0] time_i,
  output logic          hit_o,
  output logic [TW-1:0] cmp_o
);
  localparam int HI_W = TW - WIN_BITS;

  logic [TW-1:0] cmp_q, cmp_d, diff;
  logic          armed_q, armed_d;
  logic          in_win, reload, upd;

  assign diff   = time_i - cmp_q;
  assign in_win = (diff[TW-1:WIN_BITS] == HI_W'(0));
  assign hit_o  = chan_en_i && armed_q && in_win && !load_i;
  assign reload = hit_o && (AUTO_RELOAD ? cont_i : 1'b0);
  assign upd    = load_i || hit_o;

  always_comb begin
    cmp_d   = cmp_q;
    armed_d = armed_q;
    if (load_i) begin
      cmp_d   = load_val_i;
      armed_d = 1'b1;
    end else if (hit_o) begin
      armed_d = reload;
      if (reload) cmp_d = cmp_q + inc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      armed_q <= 1'b0;
    end else if (upd) begin
      cmp_q   <= cmp_d;
      armed_q <= armed_d;
    end
  end

  assign cmp_o = cmp_q;

  // R3
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !reload) |=> !armed_q);
  // R10
  load_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> armed_q && (cmp_q == $past(load_val_i)));

  generate
    if (AUTO_RELOAD) begin : g_reload_chk
      // R8
      reload_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && cont_i) |=> armed_q && (cmp_q == $past(cmp_q) + $past(inc_i)));
    end
  endgenerate
endmodule

// File: rtl/rtc_capt_unit.sv
module rtc_capt_unit #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capt_en_i,
  input  logic          evt_i,
  input  logic [TW-1:0] time_i,
  output logic          capt_hit_o,
  output logic [TW-1:0] capt_o
);
  logic          evt_prev_q;
  logic [TW-1:0] capt_q;

  assign capt_hit_o = capt_en_i && evt_i && !evt_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_prev_q <= 1'b0;
    else        evt_prev_q <= evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          capt_q <= '0;
    else if (capt_hit_o) capt_q <= time_i;
  end

  assign capt_o = capt_q;

  // R7
  capt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capt_hit_o |=> capt_q == $past(time_i));
  // R6
  capt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capt_en_i |=> $stable(capt_q));
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] flag_q, flag_d, evt_q;
  logic         upd;

  assign flag_d = (flag_q & ~clr_i) | set_i;
  assign upd    = |(set_i | clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= '0;
    else if (upd) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= set_i;
  end

  assign flag_o = flag_q;
  assign evt_o  = evt_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chk
      // R5
      evt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q[g] |-> flag_q[g]);
      // R5
      w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[g] && !set_i[g]) |=> !flag_q[g]);
      // R5
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
    end
  endgenerate
endmodule

// File: rtl/rtc_event_channels.sv
module rtc_event_channels
  import rtc_evt_pkg::*;
#(
  parameter int TW       = 32,
  parameter int WIN_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [TW-1:0]     wr_data,
  input  logic [2:0]        rd_addr,
  output logic [TW-1:0]     rd_data,
  input  logic [TW-1:0]     time_view,
  input  logic              capt_in,
  output logic [NUM_CH-1:0] chan_flag,
  output logic [NUM_CH-1:0] chan_evt
);
  logic              rst_meta_q, rst_sync_q;
  logic [NUM_CH-1:0] ch_en, load, clr, cmp_hit, set;
  logic              capm, cont, capt_hit;
  logic [TW-1:0]     inc, capt_val;
  logic [TW-1:0]     cmp_val [NUM_CH];
  logic [NUM_CH-1:0] cmp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rtc_evt_cfg #(.TW(TW)) u_cfg (
    .clk(clk), .rst_n(rst_sync_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr),
    .cmp0_i(cmp_val[0]), .cmp1_i(cmp_val[1]), .cmp2_i(cmp_val[2]),
    .capt_i(capt_val), .flag_i(chan_flag),
    .rd_data(rd_data), .ch_en_o(ch_en), .capt_mode_o(capm),
    .cont_mode_o(cont), .inc_o(inc), .load_o(load), .clr_o(clr)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      if (g == 1) begin : g_mode
        assign cmp_en[g] = ch_en[g] && !capm;
      end else begin : g_plain
        assign cmp_en[g] = ch_en[g];
      end
      rtc_cmp_unit #(.TW(TW), .WIN_BITS(WIN_BITS), .AUTO_RELOAD(g == 2)) u_cmp (
        .clk(clk), .rst_n(rst_sync_q),
        .chan_en_i(cmp_en[g]), .load_i(load[g]), .load_val_i(wr_data),
        .cont_i(cont), .inc_i(inc), .time_i(time_view),
        .hit_o(cmp_hit[g]), .cmp_o(cmp_val[g])
      );
    end
  endgenerate

  rtc_capt_unit #(.TW(TW)) u_capt (
    .clk(clk), .rst_n(rst_sync_q),
    .capt_en_i(ch_en[1] && capm), .evt_i(capt_in), .time_i(time_view),
    .capt_hit_o(capt_hit), .capt_o(capt_val)
  );

  assign set = cmp_hit | {1'b0, capt_hit, 1'b0};

  rtc_flag_bank #(.N(NUM_CH)) u_flags (
    .clk(clk), .rst_n(rst_sync_q),
    .set_i(set), .clr_i(clr), .flag_o(chan_flag), .evt_o(chan_evt)
  );

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !ch_en[0] |=> !chan_evt[0]);
  // R7
  capt_mode_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (capm && !capt_hit) |=> !chan_evt[1]);
endmodule

// File: tb/rtc_event_channels_bench.sv
module rtc_event_channels_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic [2:0]  rd_addr = 3'd0;
  logic [31:0] rd_data;
  logic [31:0] tv = 32'd0;
  logic        capt_in = 1'b0;
  logic [2:0]  chan_flag, chan_evt;

  int checks = 0, failures = 0;
  int cnt [3];
  logic [31:0] step = 32'd0;
  bit   done = 1'b0, live = 1'b0;

  always #10 clk = ~clk;

  rtc_event_channels u_rtc_event_channels (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .time_view(tv), .capt_in(capt_in), .chan_flag(chan_flag), .chan_evt(chan_evt)
  );

  // behavioural reference
  logic [2:0]  m_en, m_arm, m_flag, m_evt;
  logic        m_capm, m_cont, m_prev;
  logic [31:0] m_cmp [3];
  logic [31:0] m_inc, m_cap;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    logic [31:0] v = 32'd0;
    case (a)
      3'd0: begin v[0] = m_en[0]; v[8] = m_en[1]; v[16] = m_en[2]; v[9] = m_capm; v[18] = m_cont; end
      3'd1: begin v[0] = m_flag[0]; v[8] = m_flag[1]; v[16] = m_flag[2]; end
      3'd2: v = m_cmp[0];
      3'd3: v = m_cmp[1];
      3'd4: v = m_cmp[2];
      3'd5: v = m_inc;
      3'd6: v = m_cap;
      default: v = 32'd0;
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_arm = 0; m_flag = 0; m_evt = 0; m_capm = 0; m_cont = 0;
      m_prev = 0; m_inc = 0; m_cap = 0;
      for (int i = 0; i < 3; i++) m_cmp[i] = 0;
    end else begin
      logic [2:0] hit;
      logic       ch;
      for (int i = 0; i < 3; i++) begin
        logic on, ld;
        on = m_en[i] && !(i == 1 && m_capm);
        ld = wr_en && (wr_addr == 3'(i + 2));
        hit[i] = on && m_arm[i] && ((tv - m_cmp[i]) < 32'h0001_0000) && !ld;
      end
      ch = m_en[1] && m_capm && capt_in && !m_prev;
      m_prev = capt_in;
      if (ch) m_cap = tv;
      for (int i = 0; i < 3; i++) begin
        if (wr_en && wr_addr == 3'(i + 2)) begin
          m_cmp[i] = wr_data; m_arm[i] = 1;
        end else if (hit[i]) begin
          if (i == 2 && m_cont) m_cmp[i] = m_cmp[i] + m_inc;
          else m_arm[i] = 0;
        end
      end
      m_evt = hit | {1'b0, ch, 1'b0};
      if (wr_en && wr_addr == 3'd1)
        m_flag = m_flag & ~{wr_data[16], wr_data[8], wr_data[0]};
      m_flag = m_flag | m_evt;
      if (wr_en && wr_addr == 3'd0) begin
        m_en = {wr_data[16], wr_data[8], wr_data[0]};
        m_capm = wr_data[9]; m_cont = wr_data[18];
      end
      if (wr_en && wr_addr == 3'd5) m_inc = wr_data;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    #5;
    if (live) begin
      check(chan_flag == m_flag, "R2 flags vs model", 32'(chan_flag), 32'(m_flag));
      check(chan_evt == m_evt, "R2 events vs model", 32'(chan_evt), 32'(m_evt));
      check(rd_data == m_read(rd_addr), "R9 readback vs model", rd_data, m_read(rd_addr));
      for (int i = 0; i < 3; i++) if (chan_evt[i]) cnt[i]++;
    end
  end

  task automatic nxt();
    @(negedge clk);
    tv = tv + step;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    nxt(); wr_en = 1; wr_addr = a; wr_data = d;
    nxt(); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    nxt(); rd_addr = a; #1 v = rd_data;
  endtask

  task automatic finish_up();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    logic [31:0] v, t, start;
    int c0, found;
    for (int i = 0; i < 3; i++) cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    live = 1;

    // R1 reset state
    check(chan_flag == 0, "R1 flags", 32'(chan_flag), 0);
    check(chan_evt == 0, "R1 events", 32'(chan_evt), 0);
    rd(3'd0, v); check(v == 0, "R1 control", v, 0);
    rd(3'd2, v); check(v == 0, "R1 compare0", v, 0);

    // R2 future compare with running time
    step = 32'h100; tv = 32'h0003_0000;
    wr(3'd0, 32'h1);
    wr(3'd2, tv + 32'h1000);
    found = 0;
    for (int k = 0; k < 40 && found == 0; k++) begin nxt(); if (chan_evt[0]) found = 1; end
    check(found == 1, "R2 channel0 fired", 32'(found), 1);
    check(chan_flag[0], "R2 flag0 set", 32'(chan_flag), 1);

    // R3 one shot
    c0 = cnt[0];
    repeat (300) nxt();
    check(cnt[0] == c0, "R3 no refire", 32'(cnt[0] - c0), 0);

    // R5 clear by writing 1, writing 0 no effect
    wr(3'd1, 32'h0000_0100);
    check(chan_flag == 3'b001, "R5 write to other bit", 32'(chan_flag), 1);
    wr(3'd1, 32'h1);
    check(chan_flag == 0, "R5 w1c clears", 32'(chan_flag), 0);

    // R4 window boundaries, frozen time
    step = 0; t = 32'h0012_3400; nxt(); tv = t;
    wr(3'd2, t - 32'hFFFF); nxt();
    check(chan_evt[0], "R4 just inside window fires", 32'(chan_evt), 1);
    c0 = cnt[0];
    wr(3'd2, t - 32'h10000); repeat (20) nxt();
    check(cnt[0] == c0, "R4 one second past ignored", 32'(cnt[0] - c0), 0);
    wr(3'd2, t + 32'h1); repeat (20) nxt();
    check(cnt[0] == c0, "R4 future not yet", 32'(cnt[0] - c0), 0);
    tv = t + 1; nxt(); nxt();
    check(cnt[0] == c0 + 1, "R4 fires on reach", 32'(cnt[0] - c0), 1);
    tv = t;

    // R10 write collides with hit
    wr(3'd1, 32'h1);
    nxt(); wr_en = 1; wr_addr = 3'd2; wr_data = t;
    nxt();
    check(!chan_evt[0], "R10 first write edge", 32'(chan_evt), 0);
    nxt(); wr_en = 0;
    check(!chan_evt[0], "R10 write wins over hit", 32'(chan_evt), 0);
    nxt();
    check(chan_evt[0], "R10 fires after rearm", 32'(chan_evt), 1);

    // R5 set beats clear
    wr(3'd2, 32'h7FFF_0000);
    wr(3'd1, 32'h1);
    nxt(); wr_en = 1; wr_addr = 3'd2; wr_data = t;
    nxt(); wr_addr = 3'd1; wr_data = 32'h1;
    nxt(); wr_en = 0;
    check(chan_flag[0], "R5 set wins over clear", 32'(chan_flag), 1);

    // R6 disabled channel 2, then enabled
    wr(3'd0, 32'h0);
    wr(3'd4, t); repeat (10) nxt();
    check(!chan_flag[2], "R6 disabled no flag", 32'(chan_flag), 0);
    wr(3'd0, 32'h0001_0000); nxt();
    check(chan_evt[2], "R6 fires once enabled", 32'(chan_evt), 32'h4);

    // R6 capture disabled
    wr(3'd0, 32'h0000_0200);
    nxt(); capt_in = 1; repeat (3) nxt(); capt_in = 0; nxt();
    rd(3'd6, v);
    check(v == 0, "R6 no capture when disabled", v, 0);
    check(!chan_flag[1], "R6 no flag1 when disabled", 32'(chan_flag), 0);

    // R7 capture
    t = 32'h0A0B_C0D0; tv = t;
    wr(3'd0, 32'h0000_0300);
    c0 = cnt[1];
    nxt(); capt_in = 1; repeat (3) nxt(); capt_in = 0; nxt();
    rd(3'd6, v);
    check(v == t, "R7 captured time", v, t);
    check(cnt[1] == c0 + 1, "R7 one event per edge", 32'(cnt[1] - c0), 1);
    check(chan_flag[1], "R7 flag1", 32'(chan_flag), 32'h2);
    c0 = cnt[1];
    wr(3'd3, t); repeat (10) nxt();
    check(cnt[1] == c0, "R7 compare ignored in capture mode", 32'(cnt[1] - c0), 0);
    tv = t + 32'h55; nxt(); capt_in = 1; nxt(); capt_in = 0; nxt();
    rd(3'd6, v);
    check(v == t + 32'h55, "R7 second capture", v, t + 32'h55);

    // R8 continuous channel 2
    wr(3'd0, 32'h0005_0000);
    wr(3'd5, 32'h1000);
    step = 32'h100;
    start = tv + 32'h1000;
    c0 = cnt[2];
    wr(3'd4, start);
    repeat (100) nxt();
    step = 0; repeat (3) nxt();
    rd(3'd4, v);
    check((cnt[2] - c0) >= 5 && (cnt[2] - c0) <= 7, "R8 periodic count", 32'(cnt[2] - c0), 6);
    check(v == start + 32'(cnt[2] - c0) * 32'h1000, "R8 compare advanced", v,
          start + 32'(cnt[2] - c0) * 32'h1000);

    // R9 map
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v);
    check(v == 32'h0005_0301, "R9 control fields", v, 32'h0005_0301);
    rd(3'd5, v); check(v == 32'h1000, "R9 increment", v, 32'h1000);
    wr(3'd0, 32'h0);
    wr(3'd6, 32'h1234_5678); rd(3'd6, v);
    check(v == t + 32'h55, "R9 capture read-only", v, t + 32'h55);
    rd(3'd7, v); check(v == 0, "R9 unmapped", v, 0);

    repeat (3) nxt();
    done = 1;
    finish_up();
  end
endmodule